// File: doc/BRIEF.md
# Software Store Command Recognizer

This block sits beside the bus interface of a nonvolatile-backed memory. It looks at each sampled bus cycle and finds the special command cycles. A command cycle is one in which chip enable, write enable and the nonvolatile enable are all low while output enable is high. On those cycles it compares the address and data against a three-step unlock sequence. When the third step completes, the block raises one of three request pulses: store the RAM image now, arm automatic store on supply loss, or disarm automatic store.

The bus interface presents `cyc_valid` for one clock for each bus cycle, together with the sampled control levels, the 9-bit address and the 8-bit data. The request outputs are registered. Each one is a single-clock pulse that the storage controller consumes. The block does not run the store itself and does not model the RAM.

Top module: `swcmd_recognizer`

## Requirements
- R1: A sampled cycle counts as a command step only when `cyc_valid`=1, `ce_n`=0, `we_n`=0, `ne_n`=0 and `oe_n`=1. A command-looking cycle with `oe_n`=0 is not a step and cannot complete a sequence.
- R2: The first step is a command cycle with address 0x155 and data 0xAA.
- R3: The second step, which must directly follow the first among the command cycles, has address 0x0AA and data 0x55.
- R4: A third step with address 0x155 and data 0x33 pulses `store_req`.
- R5: A third step with address 0x155 and data 0xCC pulses `arm_req`.
- R6: A third step with address 0x155 and data 0xCD pulses `disarm_req`.
- R7: A third step with any other data, or with an address other than 0x155, produces no pulse and leaves the detector idle unless that cycle is itself a valid first step.
- R8: A command cycle that does not match the expected step drops the partial sequence, and the same cycle is tested again as a first step.
- R9: Any selected cycle (`cyc_valid`=1, `ce_n`=0) that is not a command cycle, such as a RAM read or write, clears the partial sequence.
- R10: Synchronous active-high `rst` clears the partial sequence. The outputs are low during reset and in the first cycle after it.
- R11: A request output is high for exactly one clock. That clock directly follows the clock edge that samples the third step, and at most one output is high at a time.
- R12: Clocks with `cyc_valid`=0, and valid cycles with `ce_n`=1, leave the partial sequence untouched.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cyc_valid | input | 1 | One-clock strobe marking a sampled bus cycle |
| ce_n | input | 1 | Chip enable level during the cycle (low active) |
| we_n | input | 1 | Write enable level during the cycle (low active) |
| ne_n | input | 1 | Nonvolatile enable level during the cycle (low active) |
| oe_n | input | 1 | Output enable level during the cycle (low active) |
| cyc_addr | input | 9 | Cycle address |
| cyc_data | input | 8 | Cycle write data |
| store_req | output | 1 | Pulse: store RAM image now |
| arm_req | output | 1 | Pulse: enable automatic store |
| disarm_req | output | 1 | Pulse: disable automatic store |

## Verification
The bench targets sequences that restart in the middle. A repeated first step, and a full prefix arriving right after an unrecognised third step, must both still unlock. A design that resets without rechecking the breaking cycle would miss these. It checks that a RAM read between steps, or a third step with output enable low, kills the sequence. A design that looks only at command cycles would wrongly fire. Deselected cycles and idle clocks between steps must not disturb progress, and a reset in the middle must discard it. The bench samples every pulse on its exact clock and checks that it drops on the following one, which catches stretched or early pulses.

// File: rtl/swcmd_pkg.sv
package swcmd_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_KEY1 = 2'd1,
    ST_KEY2 = 2'd2
  } seq_state_t;

  // classification of one sampled bus cycle
  typedef struct packed {
    logic cmd;    // qualified command step
    logic other;  // selected cycle that is not a command step
  } cyc_class_t;

  localparam int NUM_CMDS = 3;  // index 0 store, 1 arm, 2 disarm

endpackage

// File: rtl/swcmd_qualifier.sv
module swcmd_qualifier
  import swcmd_pkg::*;
(
  input  logic       cyc_valid,
  input  logic       ce_n,
  input  logic       we_n,
  input  logic       ne_n,
  input  logic       oe_n,
  output cyc_class_t cls
);

  logic selected;

  always_comb begin
    selected  = cyc_valid && !ce_n;
    cls.cmd   = selected && !we_n && !ne_n && oe_n;
    cls.other = selected && !cls.cmd;
  end

endmodule

// File: rtl/swcmd_matcher.sv
module swcmd_matcher #(
  parameter int ADDR_W = 9,
  parameter int DATA_W = 8,
  parameter int NCMD   = 3,
  parameter logic [ADDR_W-1:0] KEY1_ADDR = 9'h155,
  parameter logic [DATA_W-1:0] KEY1_DATA = 8'hAA,
  parameter logic [ADDR_W-1:0] KEY2_ADDR = 9'h0AA,
  parameter logic [DATA_W-1:0] KEY2_DATA = 8'h55,
  parameter logic [ADDR_W-1:0] CMD_ADDR  = 9'h155,
  parameter logic [NCMD*DATA_W-1:0] CMD_CODES = {8'hCD, 8'hCC, 8'h33}
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  output logic              is_key1,
  output logic              is_key2,
  output logic [NCMD-1:0]   cmd_hit
);

  logic cmd_addr_ok;

  always_comb begin
    is_key1     = (addr == KEY1_ADDR) && (data == KEY1_DATA);
    is_key2     = (addr == KEY2_ADDR) && (data == KEY2_DATA);
    cmd_addr_ok = (addr == CMD_ADDR);
  end

  for (genvar g = 0; g < NCMD; g++) begin : g_code
    assign cmd_hit[g] = cmd_addr_ok && (data == CMD_CODES[g*DATA_W +: DATA_W]);
  end

endmodule

// File: rtl/swcmd_seq.sv
module swcmd_seq
  import swcmd_pkg::*;
#(
  parameter int NCMD = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  cyc_class_t      cls,
  input  logic            is_key1,
  input  logic            is_key2,
  input  logic [NCMD-1:0] cmd_hit,
  output logic [NCMD-1:0] pulse
);

  seq_state_t state;
  seq_state_t state_nx;
  logic [NCMD-1:0] pulse_nx;

  always_comb begin
    state_nx = state;
    pulse_nx = '0;
    if (cls.other) begin
      state_nx = ST_IDLE;
    end else if (cls.cmd) begin
      if (state == ST_KEY2 && |cmd_hit) begin
        pulse_nx = cmd_hit;
        state_nx = ST_IDLE;
      end else if (state == ST_KEY1 && is_key2) begin
        state_nx = ST_KEY2;
      end else if (is_key1) begin
        state_nx = ST_KEY1;  // breaking cycle retried as first step
      end else begin
        state_nx = ST_IDLE;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      pulse <= '0;
    end else begin
      state <= state_nx;
      pulse <= pulse_nx;
    end
  end

endmodule

// File: rtl/swcmd_recognizer.sv
module swcmd_recognizer
  import swcmd_pkg::*;
#(
  parameter int ADDR_W = 9,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cyc_valid,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              ne_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] cyc_addr,
  input  logic [DATA_W-1:0] cyc_data,
  output logic              store_req,
  output logic              arm_req,
  output logic              disarm_req
);

  localparam int NCMD = NUM_CMDS;

  cyc_class_t      cls;
  logic            is_key1;
  logic            is_key2;
  logic [NCMD-1:0] cmd_hit;
  logic [NCMD-1:0] pulse;

  swcmd_qualifier u_qual (
    .cyc_valid (cyc_valid),
    .ce_n      (ce_n),
    .we_n      (we_n),
    .ne_n      (ne_n),
    .oe_n      (oe_n),
    .cls       (cls)
  );

  swcmd_matcher #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .NCMD   (NCMD)
  ) u_match (
    .addr    (cyc_addr),
    .data    (cyc_data),
    .is_key1 (is_key1),
    .is_key2 (is_key2),
    .cmd_hit (cmd_hit)
  );

  swcmd_seq #(
    .NCMD (NCMD)
  ) u_seq (
    .clk     (clk),
    .rst     (rst),
    .cls     (cls),
    .is_key1 (is_key1),
    .is_key2 (is_key2),
    .cmd_hit (cmd_hit),
    .pulse   (pulse)
  );

  assign store_req  = pulse[0];
  assign arm_req    = pulse[1];
  assign disarm_req = pulse[2];

endmodule

// File: rtl/swcmd_recognizer_chk.sv
module swcmd_recognizer_chk #(
  parameter int ADDR_W = 9,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              cyc_valid,
  input logic              ce_n,
  input logic              we_n,
  input logic              ne_n,
  input logic              oe_n,
  input logic [ADDR_W-1:0] cyc_addr,
  input logic [DATA_W-1:0] cyc_data,
  input logic              store_req,
  input logic              arm_req,
  input logic              disarm_req
);

  logic any_req;
  logic cmd_cyc;
  assign any_req = store_req | arm_req | disarm_req;
  assign cmd_cyc = cyc_valid && !ce_n && !we_n && !ne_n && oe_n;

  assert_onehot_R11: assert property (@(posedge clk) disable iff (rst)
    $onehot0({store_req, arm_req, disarm_req}));

  assert_one_clock_R11: assert property (@(posedge clk) disable iff (rst)
    any_req |=> !any_req);

  assert_qualified_R1: assert property (@(posedge clk) disable iff (rst)
    any_req |-> $past(cmd_cyc));

  assert_store_src_R4: assert property (@(posedge clk) disable iff (rst)
    store_req |-> $past(cyc_addr == 9'h155 && cyc_data == 8'h33));

  assert_arm_src_R5: assert property (@(posedge clk) disable iff (rst)
    arm_req |-> $past(cyc_addr == 9'h155 && cyc_data == 8'hCC));

  assert_disarm_src_R6: assert property (@(posedge clk) disable iff (rst)
    disarm_req |-> $past(cyc_addr == 9'h155 && cyc_data == 8'hCD));

  assert_after_reset_R10: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !any_req);

endmodule

bind swcmd_recognizer swcmd_recognizer_chk #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .cyc_valid  (cyc_valid),
  .ce_n       (ce_n),
  .we_n       (we_n),
  .ne_n       (ne_n),
  .oe_n       (oe_n),
  .cyc_addr   (cyc_addr),
  .cyc_data   (cyc_data),
  .store_req  (store_req),
  .arm_req    (arm_req),
  .disarm_req (disarm_req)
);

// File: tb/swcmd_recognizer_test.sv
module swcmd_recognizer_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cyc_valid = 1'b0;
  logic       ce_n = 1'b1, we_n = 1'b1, ne_n = 1'b1, oe_n = 1'b1;
  logic [8:0] cyc_addr = '0;
  logic [7:0] cyc_data = '0;
  logic       store_req, arm_req, disarm_req;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  swcmd_recognizer uut (
    .clk        (clk),
    .rst        (rst),
    .cyc_valid  (cyc_valid),
    .ce_n       (ce_n),
    .we_n       (we_n),
    .ne_n       (ne_n),
    .oe_n       (oe_n),
    .cyc_addr   (cyc_addr),
    .cyc_data   (cyc_data),
    .store_req  (store_req),
    .arm_req    (arm_req),
    .disarm_req (disarm_req)
  );

  localparam logic [2:0] NONE = 3'b000, STORE = 3'b100, ARM = 3'b010, DISARM = 3'b001;

  task automatic check(input logic [2:0] act, input logic [2:0] exp, input string req);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  // one bus cycle; returns {store,arm,disarm} on the clock after sampling
  task automatic bus(input logic c, input logic w, input logic n, input logic o,
                     input logic [8:0] a, input logic [7:0] d, output logic [2:0] r);
    @(negedge clk);
    ce_n = c; we_n = w; ne_n = n; oe_n = o; cyc_addr = a; cyc_data = d;
    cyc_valid = 1'b1;
    @(negedge clk);
    cyc_valid = 1'b0; ce_n = 1'b1; we_n = 1'b1; ne_n = 1'b1; oe_n = 1'b1;
    r = {store_req, arm_req, disarm_req};
  endtask

  task automatic cmd(input logic [8:0] a, input logic [7:0] d, output logic [2:0] r);
    bus(1'b0, 1'b0, 1'b0, 1'b1, a, d, r);
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    check({store_req, arm_req, disarm_req}, NONE, "R10 reset");
    @(negedge clk);
    check({store_req, arm_req, disarm_req}, NONE, "R10 after reset");
  endtask

  task automatic t_commands();
    logic [2:0] r;
    cmd(9'h155, 8'hAA, r); check(r, NONE, "R2 step one");
    cmd(9'h0AA, 8'h55, r); check(r, NONE, "R3 step two");
    cmd(9'h155, 8'h33, r); check(r, STORE, "R4 store");
    @(negedge clk); check({store_req, arm_req, disarm_req}, NONE, "R11 one clock");
    cmd(9'h155, 8'hAA, r); cmd(9'h0AA, 8'h55, r);
    cmd(9'h155, 8'hCC, r); check(r, ARM, "R5 arm");
    cmd(9'h155, 8'hAA, r); cmd(9'h0AA, 8'h55, r);
    cmd(9'h155, 8'hCD, r); check(r, DISARM, "R6 disarm");
    @(negedge clk); check({store_req, arm_req, disarm_req}, NONE, "R11 drop");
  endtask

  task automatic t_bad_third();
    logic [2:0] r;
    cmd(9'h155, 8'hAA, r); cmd(9'h0AA, 8'h55, r);
    cmd(9'h155, 8'h34, r); check(r, NONE, "R7 unknown data");
    cmd(9'h0AA, 8'h55, r); cmd(9'h155, 8'h33, r);
    check(r, NONE, "R7 idle after unknown");
    cmd(9'h155, 8'hAA, r); cmd(9'h0AA, 8'h55, r);
    cmd(9'h154, 8'h33, r); check(r, NONE, "R7 wrong address");
  endtask

  task automatic t_recheck();
    logic [2:0] r;
    cmd(9'h155, 8'hAA, r); cmd(9'h155, 8'hAA, r); cmd(9'h0AA, 8'h55, r);
    cmd(9'h155, 8'hCC, r); check(r, ARM, "R8 repeated first step");
    cmd(9'h155, 8'hAA, r); cmd(9'h0AA, 8'h55, r);
    cmd(9'h155, 8'hAA, r); cmd(9'h0AA, 8'h55, r);
    cmd(9'h155, 8'h33, r); check(r, STORE, "R8 restart at third step");
  endtask

  task automatic t_qualify();
    logic [2:0] r;
    cmd(9'h155, 8'hAA, r); cmd(9'h0AA, 8'h55, r);
    bus(1'b0, 1'b0, 1'b0, 1'b0, 9'h155, 8'h33, r); check(r, NONE, "R1 output enable low");
    cmd(9'h155, 8'h33, r); check(r, NONE, "R1 sequence killed");
  endtask

  task automatic t_ram_between();
    logic [2:0] r;
    cmd(9'h155, 8'hAA, r);
    bus(1'b0, 1'b1, 1'b1, 1'b0, 9'h010, 8'h00, r);  // RAM read
    cmd(9'h0AA, 8'h55, r); cmd(9'h155, 8'h33, r);
    check(r, NONE, "R9 RAM read between steps");
    cmd(9'h155, 8'hAA, r); cmd(9'h0AA, 8'h55, r);
    bus(1'b0, 1'b0, 1'b1, 1'b1, 9'h155, 8'hCD, r);  // RAM write
    check(r, NONE, "R9 RAM write as third step");
    cmd(9'h155, 8'hCD, r); check(r, NONE, "R9 cleared by write");
  endtask

  task automatic t_hold();
    logic [2:0] r;
    cmd(9'h155, 8'hAA, r);
    bus(1'b1, 1'b0, 1'b0, 1'b1, 9'h0AA, 8'h00, r);  // deselected
    repeat (5) @(negedge clk);
    cmd(9'h0AA, 8'h55, r);
    bus(1'b1, 1'b1, 1'b1, 1'b0, 9'h000, 8'h00, r);
    cmd(9'h155, 8'hCD, r); check(r, DISARM, "R12 gaps ignored");
  endtask

  task automatic t_reset_mid();
    logic [2:0] r;
    cmd(9'h155, 8'hAA, r); cmd(9'h0AA, 8'h55, r);
    do_reset();
    cmd(9'h155, 8'h33, r); check(r, NONE, "R10 reset mid sequence");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_commands();
    t_bad_third();
    t_recheck();
    t_qualify();
    t_ram_between();
    t_hold();
    t_reset_mid();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule